// File: doc/BRIEF.md
# Reset and Wakeup Cause Recorder

This block keeps a record of why the chip most recently came out of reset or out of a low-power state, so that boot software can read the cause later. Five reset-cause indications come in as single-cycle pulses: external pin, watchdog, deep-stop wake, software reset, and sleep wake. A sleep wake is not a separate pin. It is inferred when the sleep-mode level is high and a qualified wakeup source pulses. Four wakeup sources also come in as single-cycle pulses: external interrupt, RTC alarm, RTC tick and battery fault. Each of them sets a sticky flag.

Two 32-bit registers are read through a simple register bus. The cause register is read-only and always holds exactly one bit. The wakeup register collects flags until software clears them by writing ones. The battery-fault source is honoured only when the 2-bit power configuration selects battery-fault wakeup.

Top module: `wake_reset_cause_rec`

## Requirements
- R1: After the asynchronous power-on reset, the cause register reads 0x0000_0001, the wakeup register reads 0, and rdata_o is 0.
- R2: When several cause pulses arrive in one cycle, only the highest-priority cause is recorded. The order, highest first, is external pin, watchdog, sleep wake, deep-stop wake, software reset.
- R3: Any new cause event clears every earlier cause bit and leaves exactly one bit set.
- R4: A sleep wake is recorded when sleep_mode_i is high and a qualified wakeup pulse arrives.
- R5: Cause register bit map: bit 0 external pin, bit 2 watchdog, bit 3 sleep wake, bit 4 deep-stop wake, bit 5 software reset. Bit 1 and bits 31:6 read 0.
- R6: Wakeup register bit map: bit 0 external interrupt, bit 1 RTC alarm, bit 4 RTC tick, bit 5 battery fault. Bits 3:2 and 31:6 read 0. A source pulse sets its bit, and the bit stays set.
- R7: Writing 1 to a wakeup bit clears it and writing 0 leaves it unchanged. If a source pulse and a write-1 to the same bit fall in the same cycle, the bit ends up set.
- R8: A battery-fault pulse sets its flag, and counts as a sleep-wake source, only while pwr_cfg_i equals 2'b01.
- R9: Writes to the cause register change nothing, and writing ones to reserved bit positions leaves them reading 0.
- R10: Offset 0x68 selects the cause register and 0x6C selects the wakeup register. Read data appears on rdata_o one cycle after the read request and reflects the register state in the request cycle. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_ext_i | input | 1 | External pin reset pulse |
| rst_wdt_i | input | 1 | Watchdog reset pulse |
| rst_dstop_i | input | 1 | Deep-stop wake pulse |
| rst_sw_i | input | 1 | Software reset pulse |
| sleep_mode_i | input | 1 | High while the chip is in sleep |
| wk_eint_i | input | 1 | External interrupt wake pulse |
| wk_alarm_i | input | 1 | RTC alarm wake pulse |
| wk_tick_i | input | 1 | RTC tick wake pulse |
| wk_batf_i | input | 1 | Battery fault wake pulse |
| pwr_cfg_i | input | 2 | Power configuration; 2'b01 enables battery-fault wake |
| sel_i | input | 1 | Bus access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after request |

## Verification
An event pulse or a bus write in cycle N updates the registers at the clock edge that closes cycle N. A read request issued in cycle N+1 or later therefore sees the new value, and that value is on rdata_o after the edge that closes the request cycle. The bench drives every input on the falling edge, holds it across one rising edge, and samples rdata_o on the following falling edge. Every expected value is thus taken exactly one register stage after the request. The set-wins case and the priority cases put their competing inputs in one and the same cycle, so they test a real collision and not two events in sequence.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 6;
  localparam int NCAUSE = 5;

  // cause bit positions (R5)
  localparam int RC_EXT = 0;
  localparam int RC_WDT = 2;
  localparam int RC_SLP = 3;
  localparam int RC_DST = 4;
  localparam int RC_SW  = 5;

  // wake bit positions (R6)
  localparam int WK_EINT = 0;
  localparam int WK_ALM  = 1;
  localparam int WK_TICK = 4;
  localparam int WK_BATF = 5;

  localparam logic [REG_W-1:0] RC_RESET = 6'b000001;
  localparam logic [REG_W-1:0] WK_MASK  = 6'b110011;
  localparam logic [1:0]       PCFG_BATF = 2'b01;

  localparam logic [ADDR_W-1:0] OFF_RC = 8'h68;
  localparam logic [ADDR_W-1:0] OFF_WK = 8'h6C;
endpackage

// File: rtl/rcr_rst_cause.sv
module rcr_rst_cause
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] cause_i,   // index 0 = highest priority
  output logic [REG_W-1:0]  rc_o
);
  localparam int POS [NCAUSE] = '{RC_EXT, RC_WDT, RC_SLP, RC_DST, RC_SW};

  logic [REG_W-1:0] rc_q, rc_d, pick;
  logic             hit, rc_ce;

  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int i = 0; i < NCAUSE; i++) begin
      if (cause_i[i] && !hit) begin
        pick[POS[i]] = 1'b1;
        hit = 1'b1;
      end
    end
    rc_ce = hit;
    rc_d  = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rc_q <= RC_RESET;
    else if (rc_ce) rc_q <= rc_d;
  end

  assign rc_o = rc_q;

  // R3
  rc_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rc_q) == 1);

  // R2
  rc_ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_i[0] |=> rc_q[RC_EXT]);

  // R2
  rc_sw_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_i[NCAUSE-1] && |cause_i[NCAUSE-2:0]) |=> !rc_q[RC_SW]);

  // R9
  rc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|cause_i) |=> $stable(rc_q));
endmodule

// File: rtl/rcr_wake_flags.sv
module rcr_wake_flags
  import rcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] wk_o
);
  logic [REG_W-1:0] wk_q, wk_d;
  logic             wk_ce;

  always_comb begin
    wk_ce = |set_i || |clr_i;
    wk_d  = ((wk_q & ~clr_i) | set_i) & WK_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wk_q <= '0;
    else if (wk_ce) wk_q <= wk_d;
  end

  assign wk_o = wk_q;

  // R7
  wk_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[WK_EINT] |=> wk_q[WK_EINT]);

  // R7
  wk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[WK_TICK] && !set_i[WK_TICK]) |=> !wk_q[WK_TICK]);

  // R9
  wk_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_q & ~WK_MASK) == '0);
endmodule

// File: rtl/rcr_regbus.sv
module rcr_regbus
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REG_W-1:0]  rc_i,
  input  logic [REG_W-1:0]  wk_i,
  output logic [REG_W-1:0]  wk_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              hit_rc, hit_wk, rd_ce;
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    hit_rc   = (addr_i == OFF_RC);
    hit_wk   = (addr_i == OFF_WK);
    rd_ce    = sel_i && !wr_i;
    wk_clr_o = (sel_i && wr_i && hit_wk) ? (wdata_i[REG_W-1:0] & WK_MASK) : '0;
    rd_d     = '0;
    if (hit_rc)      rd_d[REG_W-1:0] = rc_i;
    else if (hit_wk) rd_d[REG_W-1:0] = wk_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_ce) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !wr_i && addr_i == OFF_RC) |=> rdata_o[REG_W-1:0] == $past(rc_i));

  // R10
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !wr_i && addr_i != OFF_RC && addr_i != OFF_WK) |=> rdata_o == '0);
endmodule

// File: rtl/wake_reset_cause_rec.sv
module wake_reset_cause_rec
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_ext_i,
  input  logic              rst_wdt_i,
  input  logic              rst_dstop_i,
  input  logic              rst_sw_i,
  input  logic              sleep_mode_i,
  input  logic              wk_eint_i,
  input  logic              wk_alarm_i,
  input  logic              wk_tick_i,
  input  logic              wk_batf_i,
  input  logic [1:0]        pwr_cfg_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [REG_W-1:0]  wk_set, wk_clr, wk_val, rc_val;
  logic [NCAUSE-1:0] cause;
  logic              batf_ok, sleep_wake;

  always_comb begin
    batf_ok            = wk_batf_i && (pwr_cfg_i == PCFG_BATF);
    wk_set             = '0;
    wk_set[WK_EINT]    = wk_eint_i;
    wk_set[WK_ALM]     = wk_alarm_i;
    wk_set[WK_TICK]    = wk_tick_i;
    wk_set[WK_BATF]    = batf_ok;
    sleep_wake         = sleep_mode_i && |wk_set;
    cause              = {rst_sw_i, rst_dstop_i, sleep_wake, rst_wdt_i, rst_ext_i};
  end

  rcr_rst_cause u_cause (
    .clk(clk), .rst_n(rst_n), .cause_i(cause), .rc_o(rc_val)
  );

  rcr_wake_flags u_wake (
    .clk(clk), .rst_n(rst_n), .set_i(wk_set), .clr_i(wk_clr), .wk_o(wk_val)
  );

  rcr_regbus u_bus (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rc_i(rc_val), .wk_i(wk_val), .wk_clr_o(wk_clr),
    .rdata_o(rdata_o)
  );

  // R8
  batf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_batf_i && pwr_cfg_i != PCFG_BATF && !wk_val[WK_BATF] && !(|wk_clr))
      |=> !wk_val[WK_BATF]);

  // R4
  sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_mode_i && wk_tick_i && !rst_ext_i && !rst_wdt_i) |=> rc_val[RC_SLP]);
endmodule

// File: tb/wake_reset_cause_rec_tb.sv
module wake_reset_cause_rec_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rst_ext_i, rst_wdt_i, rst_dstop_i, rst_sw_i, sleep_mode_i;
  logic        wk_eint_i, wk_alarm_i, wk_tick_i, wk_batf_i;
  logic [1:0]  pwr_cfg_i;
  logic        sel_i, wr_i;
  logic [7:0]  addr_i;
  logic [31:0] wdata_i, rdata_o;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  wake_reset_cause_rec u_dut (.*);

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    {rst_ext_i, rst_wdt_i, rst_dstop_i, rst_sw_i} = '0;
    {wk_eint_i, wk_alarm_i, wk_tick_i, wk_batf_i} = '0;
    sel_i = 0; wr_i = 0; addr_i = '0; wdata_i = '0;
  endtask

  // assumes inputs were set before the call on a falling edge
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel_i = 1; wr_i = 0; addr_i = a;
    @(negedge clk);
    d = rdata_o;
    idle_inputs();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = v;
    step();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(rdata_o, 32'h0, "R1 rdata");
    rd(8'h68, d); chk(d, 32'h1, "R1 cause");
    rd(8'h6C, d); chk(d, 32'h0, "R1 wake");
  endtask

  task automatic t_priority();
    logic [31:0] d;
    @(negedge clk); rst_ext_i = 1; rst_wdt_i = 1; rst_sw_i = 1; step();
    rd(8'h68, d); chk(d, 32'h01, "R2 ext over all");
    @(negedge clk); rst_wdt_i = 1; rst_dstop_i = 1; rst_sw_i = 1; step();
    rd(8'h68, d); chk(d, 32'h04, "R2 wdt over dstop/sw");
    @(negedge clk); rst_dstop_i = 1; rst_sw_i = 1; step();
    rd(8'h68, d); chk(d, 32'h10, "R2 dstop over sw");
    @(negedge clk); sleep_mode_i = 1; wk_alarm_i = 1; rst_dstop_i = 1; step();
    sleep_mode_i = 0;
    rd(8'h68, d); chk(d, 32'h08, "R2 sleep over dstop");
    wr(8'h6C, 32'h33);
  endtask

  task automatic t_replace();
    logic [31:0] d;
    @(negedge clk); rst_sw_i = 1; step();
    rd(8'h68, d); chk(d, 32'h20, "R3 sw replaces, R5 bit5");
    @(negedge clk); rst_wdt_i = 1; step();
    rd(8'h68, d); chk(d, 32'h04, "R3 wdt replaces, R5 bit2");
  endtask

  task automatic t_sleep_wake();
    logic [31:0] d;
    @(negedge clk); wk_tick_i = 1; step();
    rd(8'h68, d); chk(d, 32'h04, "R4 no sleep, no cause change");
    @(negedge clk); sleep_mode_i = 1; wk_tick_i = 1; step();
    sleep_mode_i = 0;
    rd(8'h68, d); chk(d, 32'h08, "R4 sleep wake bit3");
    rd(8'h6C, d); chk(d, 32'h10, "R6 tick bit4");
  endtask

  task automatic t_wake_set();
    logic [31:0] d;
    wr(8'h6C, 32'hFFFF_FFFF);
    rd(8'h6C, d); chk(d, 32'h0, "R7 clear all");
    @(negedge clk); wk_eint_i = 1; step();
    @(negedge clk); wk_alarm_i = 1; step();
    repeat (3) @(negedge clk);
    rd(8'h6C, d); chk(d, 32'h03, "R6 eint bit0 alarm bit1 sticky");
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h6C, 32'h0);
    rd(8'h6C, d); chk(d, 32'h03, "R7 write zero no effect");
    wr(8'h6C, 32'h2);
    rd(8'h6C, d); chk(d, 32'h01, "R7 clear alarm only");
    @(negedge clk); sel_i = 1; wr_i = 1; addr_i = 8'h6C; wdata_i = 32'h1; wk_eint_i = 1; step();
    rd(8'h6C, d); chk(d, 32'h01, "R7 set wins over clear");
    wr(8'h6C, 32'h1);
  endtask

  task automatic t_batf();
    logic [31:0] d;
    @(negedge clk); rst_sw_i = 1; step();
    pwr_cfg_i = 2'b00;
    @(negedge clk); sleep_mode_i = 1; wk_batf_i = 1; step();
    rd(8'h6C, d); chk(d, 32'h0, "R8 batf ignored cfg 00");
    rd(8'h68, d); chk(d, 32'h20, "R8 no sleep cause cfg 00");
    pwr_cfg_i = 2'b01;
    @(negedge clk); wk_batf_i = 1; step();
    sleep_mode_i = 0;
    rd(8'h6C, d); chk(d, 32'h20, "R8 batf bit5 cfg 01");
    rd(8'h68, d); chk(d, 32'h08, "R8 sleep cause via batf");
    pwr_cfg_i = 2'b00;
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(8'h68, 32'hFFFF_FFFF);
    rd(8'h68, d); chk(d, 32'h08, "R9 cause write ignored");
    wr(8'h6C, 32'h20);
    @(negedge clk); wk_tick_i = 1; step();
    wr(8'h6C, 32'hFFFF_FFC0);
    rd(8'h6C, d); chk(d, 32'h10, "R9 reserved writes no effect");
  endtask

  task automatic t_bus();
    logic [31:0] d;
    rd(8'h70, d); chk(d, 32'h0, "R10 unmapped 0x70");
    rd(8'h00, d); chk(d, 32'h0, "R10 unmapped 0x00");
    @(negedge clk); sel_i = 1; wr_i = 0; addr_i = 8'h6C;
    @(negedge clk); chk(rdata_o, 32'h10, "R10 one-cycle latency");
    idle_inputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    sleep_mode_i = 0; pwr_cfg_i = 2'b00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_priority();
    t_replace();
    t_sleep_wake();
    t_wake_set();
    t_w1c();
    t_batf();
    t_ignore();
    t_bus();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule